// File: doc/BRIEF.md
# Multi-Mode Event Capture Sequencer

This block sits between a bank of four 8-bit sample converters and a 2048-word sample FIFO. It decides when a 32-bit word built from the four channel samples goes into the FIFO. A 2-bit mode input picks one of four capture schemes. The first is free-running capture that starts on a trigger and runs until the FIFO is full. The second is fixed-length blocks of 256 words, one block per trigger. The other two are event capture: the block hunts for a four-sample pseudo-digital header on channel 0, then stores one word carrying the trigger count, followed by 144 sample words. In one event mode the hunt is armed by a trigger; in the other it runs on its own, with no trigger needed.

A sample is classified against two programmable levels. A sample at or below the low level is a low pseudo-bit. A sample at or above the high level is a high pseudo-bit. Anything in between breaks the header. The FIFO full flag ends a capture span at once, even partway through an event. The busy output marks exactly the cycles in which a word is written.

Top module: `evt_capture_seq`

## Requirements
- R1: Every sample word puts channel 0 in bits 7:0, channel 1 in bits 15:8, channel 2 in bits 23:16 and channel 3 in bits 31:24. The samples are the ones present in the cycle in which `fifo_wr` is high.
- R2: In mode 2'b00, an accepted trigger starts writes in the next cycle, one word per cycle. Writing stops when `fifo_full` is high or when 2048 words have been written, whichever comes first.
- R3: In mode 2'b11, an accepted trigger writes exactly 256 words in consecutive cycles, provided the FIFO does not fill.
- R4: A trigger is accepted only while the sequencer is idle, the mode is 2'b00, 2'b01 or 2'b11, and `fifo_full` is low. Any other trigger has no effect.
- R5: Header classification uses channel 0 only. A sample is low when it is less than or equal to `low_lim`. It is high when it is not low and is greater than or equal to `high_lim`. Otherwise it is in the middle.
- R6: In mode 2'b01, the hunt starts in the cycle after an accepted trigger. The header is the consecutive sample classes low, high, low, high. A middle sample, or a high sample where a low one is expected, restarts the hunt. A low sample where a high one is expected counts as a new first bit. Header samples are never written.
- R7: In the cycle after the last header sample, `trig_count` is written with zeros above bit 11. The next 144 cycles then write sample words.
- R8: In mode 2'b10, the hunt starts one cycle after the sequencer sees the mode while idle, with no trigger. The hunt resumes in the cycle after each event's last write.
- R9: While `fifo_full` is high, no word is written and the current capture span ends. The sequencer returns to idle, or to hunting in mode 2'b10.
- R10: `busy` is high in exactly the cycles in which `fifo_wr` is high.
- R11: If the `mode` input changes while the sequencer is hunting, the hunt is abandoned and the sequencer goes idle without writing.
- R12: During and after reset the sequencer is idle, and `fifo_wr` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Capture scheme select |
| trig | input | 1 | Trigger pulse, sampled each cycle |
| adc_smp | input | 4x8 | Current samples of the four channels, index 0 is channel 0 |
| low_lim | input | 8 | Upper bound of a low pseudo-bit |
| high_lim | input | 8 | Lower bound of a high pseudo-bit |
| trig_count | input | 12 | Trigger count stored at the start of each event |
| fifo_full | input | 1 | FIFO cannot take a word this cycle |
| fifo_wr | output | 1 | Write strobe to the FIFO |
| fifo_wdata | output | 32 | Word to write |
| busy | output | 1 | High while a capture span is writing |

## Verification
Two situations are hardest to reach from the ports. The first is the FIFO filling in the middle of an event. The second is a header that only appears after a partial or overlapping false start. The bench keeps its own occupancy count and derives `fifo_full` from it. It can preload that count to just short of the capacity, so a header-synchronised event is cut after its fiftieth word and the hunt must then resume. It also feeds channel-0 sequences made of sample values exactly on each limit, middle values and repeated low values. These show that the restart rules and the inclusive comparisons place the counted word in the right cycle.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STREAM = 3'd1,
        ST_HUNT   = 3'd2,
        ST_CNTW   = 3'd3,
        ST_DATA   = 3'd4
    } cap_state_e;

    typedef enum logic [1:0] {
        PB_LOW  = 2'd0,
        PB_HIGH = 2'd1,
        PB_MID  = 2'd2
    } pbit_e;

    localparam logic [1:0] MODE_FREE    = 2'b00;
    localparam logic [1:0] MODE_TRIGHDR = 2'b01;
    localparam logic [1:0] MODE_HDR     = 2'b10;
    localparam logic [1:0] MODE_BLOCK   = 2'b11;

endpackage

// File: rtl/evt_word_packer.sv
module evt_word_packer #(
    parameter int N_CH   = 4,
    parameter int CH_W   = 8,
    parameter int TCNT_W = 12
) (
    input  logic [N_CH-1:0][CH_W-1:0] samples,
    input  logic [TCNT_W-1:0]         tcount,
    input  logic                      sel_count,
    output logic [N_CH*CH_W-1:0]      word
);
    localparam int WORD_W = N_CH * CH_W;
    localparam int PAD_W  = WORD_W - TCNT_W;

    logic [WORD_W-1:0] sample_word;

    // lane g of the word carries channel g
    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        assign sample_word[g*CH_W +: CH_W] = samples[g];
    end

    assign word = sel_count ? {{PAD_W{1'b0}}, tcount} : sample_word;

endmodule

// File: rtl/evt_hdr_hunter.sv
module evt_hdr_hunter
    import evt_cap_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [CH_W-1:0] sample,
    input  logic [CH_W-1:0] low_lim,
    input  logic [CH_W-1:0] high_lim,
    output logic            found
);
    // progress through the low/high/low/high header; bit 0 set means a high is expected
    logic [1:0] prog_d, prog_q;
    pbit_e      cls;
    logic       match;

    always_comb begin
        if (sample <= low_lim)       cls = PB_LOW;
        else if (sample >= high_lim) cls = PB_HIGH;
        else                         cls = PB_MID;
    end

    assign match = prog_q[0] ? (cls == PB_HIGH) : (cls == PB_LOW);
    assign found = active && (prog_q == 2'd3) && (cls == PB_HIGH);

    always_comb begin
        prog_d = 2'd0;
        if (active) begin
            if (match)               prog_d = prog_q + 2'd1;
            else if (cls == PB_LOW)  prog_d = 2'd1;
            else                     prog_d = 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 2'd0;
        else        prog_q <= prog_d;
    end

endmodule

// File: rtl/evt_cap_ctrl.sv
module evt_cap_ctrl
    import evt_cap_pkg::*;
#(
    parameter int FIFO_DEPTH = 2048,
    parameter int BLOCK_LEN  = 256,
    parameter int EVENT_LEN  = 144
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       mode,
    input  logic                             trig,
    input  logic                             fifo_full,
    input  logic                             found,
    output logic                             wr,
    output logic                             busy,
    output logic                             sel_count,
    output cap_state_e                       st_o,
    output logic [1:0]                       mode_o,
    output logic [$clog2(FIFO_DEPTH):0]      cnt_o
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [CW-1:0] FREE_LAST  = CW'(FIFO_DEPTH - 1);
    localparam logic [CW-1:0] BLOCK_LAST = CW'(BLOCK_LEN - 1);
    localparam logic [CW-1:0] EVENT_LAST = CW'(EVENT_LEN - 1);

    typedef struct packed {
        cap_state_e    st;
        logic [1:0]    mode;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t      ctl_d, ctl_q;
    cap_state_e ret_st;
    logic [CW-1:0] stream_last;

    always_comb begin
        ctl_d       = ctl_q;
        wr          = 1'b0;
        sel_count   = 1'b0;
        ret_st      = (ctl_q.mode == MODE_HDR) ? ST_HUNT : ST_IDLE;
        stream_last = (ctl_q.mode == MODE_FREE) ? FREE_LAST : BLOCK_LAST;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (mode == MODE_HDR) begin
                    ctl_d.st   = ST_HUNT;
                    ctl_d.mode = mode;
                end else if (trig && !fifo_full) begin
                    ctl_d.mode = mode;
                    ctl_d.cnt  = '0;
                    ctl_d.st   = (mode == MODE_TRIGHDR) ? ST_HUNT : ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (fifo_full) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    wr        = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == stream_last) ctl_d.st = ST_IDLE;
                end
            end
            ST_HUNT: begin
                if (mode != ctl_q.mode)  ctl_d.st = ST_IDLE;
                else if (found)          ctl_d.st = ST_CNTW;
            end
            ST_CNTW: begin
                if (fifo_full) begin
                    ctl_d.st = ret_st;
                end else begin
                    wr        = 1'b1;
                    sel_count = 1'b1;
                    ctl_d.cnt = '0;
                    ctl_d.st  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (fifo_full) begin
                    ctl_d.st = ret_st;
                end else begin
                    wr        = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == EVENT_LAST) ctl_d.st = ret_st;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.mode <= MODE_FREE;
            ctl_q.cnt  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // busy is decoded from the writing states on its own
    assign busy   = !fifo_full && ((ctl_q.st == ST_STREAM) || (ctl_q.st == ST_CNTW) ||
                                   (ctl_q.st == ST_DATA));
    assign st_o   = ctl_q.st;
    assign mode_o = ctl_q.mode;
    assign cnt_o  = ctl_q.cnt;

endmodule

// File: rtl/evt_capture_seq.sv
module evt_capture_seq
    import evt_cap_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int CH_W       = 8,
    parameter int TCNT_W     = 12,
    parameter int FIFO_DEPTH = 2048,
    parameter int BLOCK_LEN  = 256,
    parameter int EVENT_LEN  = 144
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode,
    input  logic                      trig,
    input  logic [N_CH-1:0][CH_W-1:0] adc_smp,
    input  logic [CH_W-1:0]           low_lim,
    input  logic [CH_W-1:0]           high_lim,
    input  logic [TCNT_W-1:0]         trig_count,
    input  logic                      fifo_full,
    output logic                      fifo_wr,
    output logic [N_CH*CH_W-1:0]      fifo_wdata,
    output logic                      busy
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    cap_state_e    st_q;
    logic [1:0]    mode_q;
    logic [CW-1:0] cnt_q;
    logic          found;
    logic          hunt_act;
    logic          sel_count;

    assign hunt_act = (st_q == ST_HUNT) && (mode == mode_q);

    evt_hdr_hunter #(.CH_W(CH_W)) hunter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (hunt_act),
        .sample   (adc_smp[0]),
        .low_lim  (low_lim),
        .high_lim (high_lim),
        .found    (found)
    );

    evt_cap_ctrl #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .BLOCK_LEN  (BLOCK_LEN),
        .EVENT_LEN  (EVENT_LEN)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .trig      (trig),
        .fifo_full (fifo_full),
        .found     (found),
        .wr        (fifo_wr),
        .busy      (busy),
        .sel_count (sel_count),
        .st_o      (st_q),
        .mode_o    (mode_q),
        .cnt_o     (cnt_q)
    );

    evt_word_packer #(.N_CH(N_CH), .CH_W(CH_W), .TCNT_W(TCNT_W)) packer_i (
        .samples   (adc_smp),
        .tcount    (trig_count),
        .sel_count (sel_count),
        .word      (fifo_wdata)
    );

endmodule

// File: rtl/evt_capture_seq_chk.sv
module evt_capture_seq_chk
    import evt_cap_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int CH_W       = 8,
    parameter int FIFO_DEPTH = 2048,
    parameter int BLOCK_LEN  = 256
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [N_CH-1:0][CH_W-1:0]        adc_smp,
    input logic [CH_W-1:0]                  low_lim,
    input logic [CH_W-1:0]                  high_lim,
    input logic                             fifo_full,
    input logic                             fifo_wr,
    input logic [N_CH*CH_W-1:0]             fifo_wdata,
    input logic                             busy,
    input cap_state_e                       st_q,
    input logic [1:0]                       mode_q,
    input logic [$clog2(FIFO_DEPTH):0]      cnt_q,
    input logic                             found,
    input logic                             sel_count
);
    // R9
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    // R12
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_HUNT) |-> (!fifo_wr && !busy));

    // R3
    block_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STREAM && mode_q == MODE_BLOCK) |-> (cnt_q < BLOCK_LEN));

    // R5
    header_end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (adc_smp[0] > low_lim && adc_smp[0] >= high_lim));

    // R1
    lane0_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !sel_count) |-> (fifo_wdata[CH_W-1:0] == adc_smp[0]));

    // R7
    count_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && sel_count) |=> (st_q == ST_DATA));

endmodule

bind evt_capture_seq evt_capture_seq_chk #(
    .N_CH(N_CH), .CH_W(CH_W), .FIFO_DEPTH(FIFO_DEPTH), .BLOCK_LEN(BLOCK_LEN)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_smp    (adc_smp),
    .low_lim    (low_lim),
    .high_lim   (high_lim),
    .fifo_full  (fifo_full),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .busy       (busy),
    .st_q       (st_q),
    .mode_q     (mode_q),
    .cnt_q      (cnt_q),
    .found      (found),
    .sel_count  (sel_count)
);

// File: tb/evt_capture_seq_tb_top.sv
module evt_capture_seq_tb_top;

    localparam int DEPTH = 2048;
    localparam int BLK   = 256;
    localparam int EVT   = 144;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode;
    logic             trig;
    logic [3:0][7:0]  adc;
    logic [7:0]       low_lim, high_lim;
    logic [11:0]      tcnt;
    logic             fifo_full;
    logic             fifo_wr;
    logic [31:0]      fifo_wdata;
    logic             busy;

    always #4 clk = ~clk;

    evt_capture_seq dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .trig(trig), .adc_smp(adc),
        .low_lim(low_lim), .high_lim(high_lim), .trig_count(tcnt),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .busy(busy)
    );

    int vectors = 0;
    int miscompares = 0;
    int occ = 0;
    int occ_lim = DEPTH;
    int n_wr = 0;
    bit done = 0;
    int seed = 7;

    // behavioural reference: 0 idle, 1 stream, 2 hunt, 3 count word, 4 event data
    int m_st = 0;
    int m_mode = 0;
    int m_cnt = 0;
    int m_prog = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic int classify(input logic [7:0] s);
        if (s <= low_lim) return 0;
        if (s >= high_lim) return 1;
        return 2;
    endfunction

    task automatic tick();
        bit         e_wr;
        logic [31:0] e_data;
        string      tag;
        int         ret;
        int         c;
        @(negedge clk);
        fifo_full = (occ >= occ_lim);
        #1;
        e_wr = 0; e_data = '0; tag = "R12";
        ret = (m_mode == 2) ? 2 : 0;
        case (m_st)
            0: begin
                tag = "R4";
                if (mode == 2'b10) begin m_st = 2; m_mode = 2; m_prog = 0; end
                else if (trig && !fifo_full) begin
                    m_mode = int'(mode); m_cnt = 0; m_prog = 0;
                    m_st = (mode == 2'b01) ? 2 : 1;
                end
            end
            1: begin
                tag = (m_mode == 0) ? "R2" : "R3";
                if (fifo_full) m_st = 0;
                else begin
                    e_wr = 1; e_data = adc;
                    if (m_cnt == ((m_mode == 0) ? DEPTH : BLK) - 1) m_st = 0;
                    m_cnt++;
                end
            end
            2: begin
                tag = "R6";
                if (int'(mode) != m_mode) begin m_st = 0; m_prog = 0; end
                else begin
                    c = classify(adc[0]);
                    if (m_prog == 3 && c == 1) begin m_st = 3; m_prog = 0; end
                    else if ((m_prog % 2 == 1 && c == 1) || (m_prog % 2 == 0 && c == 0)) m_prog++;
                    else if (c == 0) m_prog = 1;
                    else m_prog = 0;
                end
            end
            3: begin
                tag = "R7";
                if (fifo_full) m_st = ret;
                else begin e_wr = 1; e_data = {20'd0, tcnt}; m_st = 4; m_cnt = 0; end
            end
            default: begin
                tag = "R7";
                if (fifo_full) m_st = ret;
                else begin
                    e_wr = 1; e_data = adc;
                    if (m_cnt == EVT - 1) m_st = ret;
                    m_cnt++;
                end
            end
        endcase
        if (fifo_full) tag = "R9";
        chk(tag, "fifo_wr", {31'd0, fifo_wr}, {31'd0, e_wr});
        chk("R10", "busy vs write span", {31'd0, busy}, {31'd0, e_wr});
        if (e_wr) chk((tag == "R7" && e_data[31:12] == 0 && m_st == 4 && m_cnt == 0) ? "R7" : "R1",
                      "fifo_wdata", fifo_wdata, e_data);
        if (fifo_wr) n_wr++;
        if (e_wr) occ++;
        @(posedge clk);
        #1;
    endtask

    task automatic set_data();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        adc[0] = 8'h40 + 8'(seed % 96);
        adc[1] = 8'(seed >> 3);
        adc[2] = 8'(seed >> 11);
        adc[3] = 8'(seed >> 19);
    endtask

    task automatic run_data(input int n);
        for (int i = 0; i < n; i++) begin set_data(); tick(); end
    endtask

    task automatic hdr_smp(input logic [7:0] v);
        set_data(); adc[0] = v; tick();
    endtask

    task automatic pulse_trig();
        trig = 1'b1; set_data(); tick(); trig = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode = 2'b00; trig = 0; adc = '0; low_lim = 8'h20; high_lim = 8'hC0;
        tcnt = 12'h000; fifo_full = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R12", "fifo_wr in reset", {31'd0, fifo_wr}, 32'd0);
        chk("R12", "busy in reset", {31'd0, busy}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1;

        // R12: idle with no trigger stays silent
        n_wr = 0; run_data(5);
        chk("R12", "writes while idle", n_wr, 0);

        // R3: fixed block, second trigger mid-block ignored (R4)
        mode = 2'b11; n_wr = 0; pulse_trig(); run_data(100);
        trig = 1; run_data(1); trig = 0;
        run_data(170);
        chk("R3", "block word count", n_wr, BLK);
        chk("R4", "trigger during block ignored", n_wr, BLK);

        // R4: trigger with FIFO full ignored
        occ = DEPTH; n_wr = 0; pulse_trig(); run_data(10);
        chk("R4", "writes after trigger at full", n_wr, 0);

        // R4: trigger in mode 10 is not a start condition; go through idle mode 00
        // R2: free run stopped by full
        occ = DEPTH - 48; mode = 2'b00; n_wr = 0; pulse_trig(); run_data(60);
        chk("R2", "free run stopped by full", n_wr, 48);

        // R2: free run stopped by word limit with full held low
        occ = 0; occ_lim = 1000000; n_wr = 0; pulse_trig(); run_data(DEPTH + 10);
        chk("R2", "free run word limit", n_wr, DEPTH);
        occ = 0; occ_lim = DEPTH;

        // R6: header before trigger is not hunted; then restarts and limit equality (R5)
        mode = 2'b01; tcnt = 12'hABC; n_wr = 0;
        hdr_smp(8'h10); hdr_smp(8'hF0); hdr_smp(8'h10); hdr_smp(8'hF0);
        chk("R6", "no hunt before trigger", n_wr, 0);
        pulse_trig();
        hdr_smp(8'h80); hdr_smp(8'h20); hdr_smp(8'hF0); hdr_smp(8'h80);
        hdr_smp(8'h20); hdr_smp(8'hF0); hdr_smp(8'h00); hdr_smp(8'h00);
        hdr_smp(8'hC0); hdr_smp(8'h15);
        chk("R6", "no write during header", n_wr, 0);
        hdr_smp(8'hC0);
        run_data(EVT + 6);
        chk("R7", "event word count", n_wr, EVT + 1);
        chk("R5", "limit-equal samples accepted", n_wr, EVT + 1);

        // R8: self-armed hunt, two back-to-back events
        mode = 2'b10; tcnt = 12'h123; n_wr = 0; run_data(3);
        hdr_smp(8'h10); hdr_smp(8'hF0); hdr_smp(8'h10); hdr_smp(8'hF0);
        run_data(EVT + 1);
        hdr_smp(8'h10); hdr_smp(8'hF0); hdr_smp(8'h10); hdr_smp(8'hF0);
        run_data(EVT + 4);
        chk("R8", "two self-armed events", n_wr, 2 * (EVT + 1));

        // R9: event cut by full, hunt resumes afterwards
        occ = DEPTH - 50; n_wr = 0;
        hdr_smp(8'h10); hdr_smp(8'hF0); hdr_smp(8'h10); hdr_smp(8'hF0);
        run_data(EVT + 4);
        chk("R9", "partial event length", n_wr, 50);
        occ = 0; n_wr = 0;
        hdr_smp(8'h10); hdr_smp(8'hF0); hdr_smp(8'h10); hdr_smp(8'hF0);
        run_data(EVT + 4);
        chk("R9", "hunt resumed after cut", n_wr, EVT + 1);

        // R11: mode changes during hunt
        mode = 2'b00; run_data(3);
        mode = 2'b01; n_wr = 0; pulse_trig();
        hdr_smp(8'h10); hdr_smp(8'hF0); hdr_smp(8'h10);
        mode = 2'b11;
        hdr_smp(8'hF0); run_data(5);
        mode = 2'b01;
        hdr_smp(8'h10); hdr_smp(8'hF0); hdr_smp(8'h10); hdr_smp(8'hF0);
        run_data(5);
        chk("R11", "abandoned hunt writes", n_wr, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule